// File: doc/BRIEF.md
# Register-Driven SPI Shift Engine

This block is an SPI host controlled through a small 32-bit register window. Each accepted write to the shift-command register starts one shift of 1 to 32 bits. Transmit bits come from the outgoing-data register and are sent MSB first. Receive bits are gathered into the incoming-data register. A divider register sets the SCLK rate. A pin-level register sets the idle levels of the three active-low selects, SCLK and MOSI.

A command names one chip select and a final flag. Without the final flag, the chosen select stays low after the last bit, so a longer transaction can be built from several commands. A busy bit in the command register reads as one while a shift runs. The hardware clears it on completion, and software polls it. Shift requests do nothing until the enable bit in the function register is set.

Top module: `spi_shift_host`

## Requirements
- R1: After synchronous reset, all selects are high and SCLK and MOSI are low. The function register reads 0, the pin-level register reads 0x00070000, and the command and incoming-data registers read 0.
- R2: While bit 0 of the function register (byte offset 0x00) is clear, a write to the command register starts nothing: busy stays 0 and the pins keep their idle levels.
- R3: The divider value d sits in bits [5:0] at offset 0x04. Each SCLK half period lasts d+1 system cycles. A shift of n bits keeps busy high for exactly 2·n·(d+1) cycles.
- R4: The command register is at offset 0x14. Bit 31 is start (write) and busy (read). Bits 30:28 are a one-hot chip select, with bit 28 selecting select 0. Bit 26 is the final flag. Bits [5:0] are the bit count, read back as written. A count of 0 or above 32 shifts 32 bits.
- R5: The outgoing data at offset 0x10 is right-aligned. For an n-bit shift, bit n-1 is sent first and bit 0 is sent last.
- R6: The incoming data at offset 0x18 reads 0 from the cycle after a shift starts. Received bits enter at bit 0, so after an n-bit shift the first bit received sits in bit n-1.
- R7: With the final flag set, the chosen select returns high when busy clears. With it clear, that select stays low after the shift and the other selects follow the pin-level register.
- R8: A command write while busy is ignored. The running shift keeps its length and data, and the command fields read back unchanged.
- R9: Mode 0 timing applies. SCLK is low whenever no shift runs. The select goes low one half period before the first rising edge. MOSI changes only on falling edges, and MISO is sampled on rising edges.
- R10: The pin-level register is at offset 0x08. Bits 18:16 set the idle levels of selects 2..0, bit 1 sets the idle SCLK level and bit 0 sets the idle MOSI level. These levels drive the pins whenever no shift runs and no select is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 5 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 3 | Active-low chip selects 2..0 |

## Verification
A wrong bit counter shows up as a busy window whose length differs from 2·n·(d+1). That difference can be seen on the cycle busy clears. A fault in the transmit alignment or shift direction corrupts the word the attached device collects. A fault in receive capture corrupts the incoming-data register, which is read as soon as busy drops. A fault in select holding, or in the enable and busy gating, appears at spi_cs_n or in the command readback on the first polled cycle after the shift.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;

    localparam int WORD_W  = 32;
    localparam int DIV_W   = 6;
    localparam int NBITS_W = 6;
    localparam int NUM_CS  = 3;
    localparam int ADDR_W  = 5;

    localparam logic [ADDR_W-1:0] OFS_FUNC  = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_CLK   = 5'h04;
    localparam logic [ADDR_W-1:0] OFS_PINS  = 5'h08;
    localparam logic [ADDR_W-1:0] OFS_DOUT  = 5'h10;
    localparam logic [ADDR_W-1:0] OFS_SHIFT = 5'h14;
    localparam logic [ADDR_W-1:0] OFS_DIN   = 5'h18;

    localparam int SH_GO_BIT   = 31;
    localparam int SH_CS_LSB   = 28;
    localparam int SH_FINAL    = 26;
    localparam int PIN_CS_LSB  = 16;
    localparam int PIN_SCLK    = 1;
    localparam int PIN_MOSI    = 0;

    typedef struct packed {
        logic [NUM_CS-1:0]  cs_sel;
        logic               final_f;
        logic [NBITS_W-1:0] nbits;
    } shift_cmd_t;

    typedef struct packed {
        logic [NUM_CS-1:0] cs_lvl;
        logic              sclk_lvl;
        logic              mosi_lvl;
    } pin_lvl_t;

    localparam pin_lvl_t PIN_RESET = '{cs_lvl: '1, sclk_lvl: 1'b0, mosi_lvl: 1'b0};

    function automatic shift_cmd_t decode_cmd(input logic [WORD_W-1:0] w);
        shift_cmd_t c;
        c.cs_sel  = w[SH_CS_LSB +: NUM_CS];
        c.final_f = w[SH_FINAL];
        c.nbits   = w[NBITS_W-1:0];
        return c;
    endfunction

    function automatic logic [NBITS_W-1:0] eff_len(input logic [NBITS_W-1:0] n);
        if (n == '0 || n > NBITS_W'(WORD_W))
            return NBITS_W'(WORD_W);
        return n;
    endfunction

endpackage

// File: rtl/spi_reg_file.sv
module spi_reg_file
    import spi_eng_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [WORD_W-1:0] wdata_i,
    output logic [WORD_W-1:0] rdata_o,
    input  logic              busy_i,
    input  logic [WORD_W-1:0] rx_i,
    output logic              en_o,
    output logic [DIV_W-1:0]  div_o,
    output pin_lvl_t          pins_o,
    output logic [WORD_W-1:0] dout_o,
    output logic              start_o,
    output shift_cmd_t        cmd_o
);
    logic              en_q;
    logic [DIV_W-1:0]  div_q;
    pin_lvl_t          pins_q;
    logic [WORD_W-1:0] dout_q;
    shift_cmd_t        cmd_q;
    logic              shift_wr;

    assign shift_wr = wr_i && (addr_i == OFS_SHIFT);
    assign start_o  = shift_wr && wdata_i[SH_GO_BIT] && en_q && !busy_i;
    assign cmd_o    = decode_cmd(wdata_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= 1'b0;
            div_q  <= '0;
            pins_q <= PIN_RESET;
            dout_q <= '0;
            cmd_q  <= '0;
        end else if (wr_i) begin
            case (addr_i)
                OFS_FUNC: en_q  <= wdata_i[0];
                OFS_CLK:  div_q <= wdata_i[DIV_W-1:0];
                OFS_PINS: begin
                    pins_q.cs_lvl   <= wdata_i[PIN_CS_LSB +: NUM_CS];
                    pins_q.sclk_lvl <= wdata_i[PIN_SCLK];
                    pins_q.mosi_lvl <= wdata_i[PIN_MOSI];
                end
                OFS_DOUT: dout_q <= wdata_i;
                OFS_SHIFT: if (start_o) cmd_q <= cmd_o;
                default: ;
            endcase
        end
    end

    always_comb begin
        rdata_o = '0;
        case (addr_i)
            OFS_FUNC:  rdata_o[0] = en_q;
            OFS_CLK:   rdata_o[DIV_W-1:0] = div_q;
            OFS_PINS: begin
                rdata_o[PIN_CS_LSB +: NUM_CS] = pins_q.cs_lvl;
                rdata_o[PIN_SCLK] = pins_q.sclk_lvl;
                rdata_o[PIN_MOSI] = pins_q.mosi_lvl;
            end
            OFS_DOUT:  rdata_o = dout_q;
            OFS_SHIFT: begin
                rdata_o[SH_GO_BIT] = busy_i;
                rdata_o[SH_CS_LSB +: NUM_CS] = cmd_q.cs_sel;
                rdata_o[SH_FINAL] = cmd_q.final_f;
                rdata_o[NBITS_W-1:0] = cmd_q.nbits;
            end
            OFS_DIN:   rdata_o = rx_i;
            default:   rdata_o = '0;
        endcase
    end

    assign en_o   = en_q;
    assign div_o  = div_q;
    assign pins_o = pins_q;
    assign dout_o = dout_q;

    // R8: a command write during a running shift leaves the stored command alone
    p_busy_write_ignored_r8: assert property (@(posedge clk) disable iff (rst)
        (shift_wr && busy_i) |=> $stable(cmd_q));

endmodule

// File: rtl/spi_half_tick.sv
module spi_half_tick #(
    parameter int DIV_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);
    logic [DIV_W-1:0] cnt_q;

    assign tick_o = run_i && (cnt_q == div_i);

    always_ff @(posedge clk) begin
        if (rst || !run_i)
            cnt_q <= '0;
        else if (cnt_q == div_i)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    // R3: with a divider above zero, half-period ticks never come back to back
    p_tick_gap_r3: assert property (@(posedge clk) disable iff (rst)
        (tick_o && div_i != '0 && $stable(div_i)) |=> !tick_o);

endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core
    import spi_eng_pkg::*;
#(
    parameter int DATA_W = WORD_W,
    parameter int CNT_W  = $clog2(DATA_W) + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  shift_cmd_t        cmd_i,
    input  logic [DATA_W-1:0] tx_word_i,
    input  logic              tick_i,
    input  logic              miso_i,
    output logic              busy_o,
    output logic              sclk_o,
    output logic              mosi_o,
    output logic [NUM_CS-1:0] cs_act_o,
    output logic [DATA_W-1:0] rx_word_o
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DATA_W);

    logic              busy_q, sclk_q, final_q;
    logic [DATA_W-1:0] tx_q, rx_q;
    logic [CNT_W-1:0]  left_q, len;
    logic [NUM_CS-1:0] cs_q;

    assign len = CNT_W'(eff_len(cmd_i.nbits));

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q  <= 1'b0;
            sclk_q  <= 1'b0;
            final_q <= 1'b0;
            tx_q    <= '0;
            rx_q    <= '0;
            left_q  <= '0;
            cs_q    <= '0;
        end else if (start_i) begin
            busy_q  <= 1'b1;
            sclk_q  <= 1'b0;
            final_q <= cmd_i.final_f;
            tx_q    <= tx_word_i << (FULL - len);
            rx_q    <= '0;
            left_q  <= len;
            cs_q    <= cmd_i.cs_sel;
        end else if (busy_q && tick_i) begin
            if (!sclk_q) begin
                sclk_q <= 1'b1;
                rx_q   <= {rx_q[DATA_W-2:0], miso_i};
            end else begin
                sclk_q <= 1'b0;
                tx_q   <= tx_q << 1;
                left_q <= left_q - 1'b1;
                if (left_q == 1) begin
                    busy_q <= 1'b0;
                    if (final_q) cs_q <= '0;
                end
            end
        end
    end

    assign busy_o    = busy_q;
    assign sclk_o    = sclk_q;
    assign mosi_o    = tx_q[DATA_W-1];
    assign cs_act_o  = cs_q;
    assign rx_word_o = rx_q;

    // R9: no clock activity outside a shift
    p_sclk_low_idle_r9: assert property (@(posedge clk) disable iff (rst)
        !busy_q |-> !sclk_q);
    // R9: a shift opens with SCLK low (select setup half period)
    p_first_half_low_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_q) |-> !sclk_q);
    // R6: capture register starts empty
    p_rx_cleared_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_q) |-> (rx_q == '0));
    // R7: final shift releases every select
    p_release_r7: assert property (@(posedge clk) disable iff (rst)
        ($fell(busy_q) && final_q) |-> (cs_q == '0));
    // R4: remaining count stays within 1..DATA_W while running
    p_left_range_r4: assert property (@(posedge clk) disable iff (rst)
        busy_q |-> (left_q != '0 && left_q <= FULL));

endmodule

// File: rtl/spi_shift_host.sv
module spi_shift_host
    import spi_eng_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              spi_sclk,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic [NUM_CS-1:0] spi_cs_n
);
    logic              en, start, busy, tick, core_sclk, core_mosi;
    logic [DIV_W-1:0]  div;
    pin_lvl_t          pins;
    logic [WORD_W-1:0] dout, rx;
    shift_cmd_t        cmd;
    logic [NUM_CS-1:0] cs_act;

    spi_reg_file u_regs (
        .clk(clk), .rst(rst), .wr_i(bus_wr), .addr_i(bus_addr), .wdata_i(bus_wdata),
        .rdata_o(bus_rdata), .busy_i(busy), .rx_i(rx), .en_o(en), .div_o(div),
        .pins_o(pins), .dout_o(dout), .start_o(start), .cmd_o(cmd)
    );

    spi_half_tick #(.DIV_W(DIV_W)) u_tick (
        .clk(clk), .rst(rst), .run_i(busy), .div_i(div), .tick_o(tick)
    );

    spi_shift_core #(.DATA_W(WORD_W)) u_core (
        .clk(clk), .rst(rst), .start_i(start), .cmd_i(cmd), .tx_word_i(dout),
        .tick_i(tick), .miso_i(spi_miso), .busy_o(busy), .sclk_o(core_sclk),
        .mosi_o(core_mosi), .cs_act_o(cs_act), .rx_word_o(rx)
    );

    assign spi_sclk = busy ? core_sclk : pins.sclk_lvl;
    assign spi_mosi = busy ? core_mosi : pins.mosi_lvl;
    assign spi_cs_n = pins.cs_lvl & ~cs_act;

    // R2: with the engine disabled a start request leaves it idle
    p_disabled_ignore_r2: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == OFS_SHIFT && !en && !busy) |=> !busy);

endmodule

// File: tb/spi_shift_host_bench.sv
module spi_shift_host_bench;
    localparam logic [4:0] A_FUNC = 5'h00, A_CLK = 5'h04, A_PINS = 5'h08,
                           A_DOUT = 5'h10, A_SHIFT = 5'h14, A_DIN = 5'h18;

    logic        clk = 1'b0, rst = 1'b1, bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic        spi_sclk, spi_mosi, spi_miso;
    logic [2:0]  spi_cs_n;

    int nchk = 0, nerr = 0;
    longint cyc = 0;
    logic [31:0] stx = '0, srx = '0;

    spi_shift_host u_spi_shift_host (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso), .spi_cs_n(spi_cs_n)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // attached device model, mode 0
    assign spi_miso = stx[31];
    always @(negedge spi_sclk) stx <= stx << 1;
    always @(posedge spi_sclk) srx <= {srx[30:0], spi_mosi};

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    function automatic int eff(input int n);
        return (n == 0 || n > 32) ? 32 : n;
    endfunction

    function automatic logic [31:0] mask(input int n);
        return (n == 32) ? 32'hFFFF_FFFF : 32'((64'd1 << n) - 1);
    endfunction

    // waits for busy to drop, returns cycles from the stamp
    task automatic wait_idle(input longint t0, output longint k);
        logic [31:0] v;
        int guard = 0;
        rd(A_SHIFT, v);
        while (v[31] && guard < 20000) begin
            @(negedge clk);
            rd(A_SHIFT, v);
            guard++;
        end
        k = cyc - t0;
    endtask

    task automatic do_shift(input int d, input int nf, input logic [2:0] cs1h,
                            input bit fin, input logic [31:0] dout, input logic [31:0] pat);
        logic [31:0] v;
        longint t0, k;
        int n;
        n = eff(nf);
        wr(A_CLK, 32'(d));
        wr(A_DOUT, dout);
        stx = pat; srx = '0;
        wr(A_SHIFT, {1'b1, cs1h, 1'b0, fin, 20'b0, 6'(nf)});
        t0 = cyc;
        check("R9 select low at start", {29'b0, spi_cs_n}, {29'b0, ~cs1h});
        check("R9 sclk low at start", {31'b0, spi_sclk}, 32'b0);
        rd(A_DIN, v);
        check("R6 incoming cleared at start", v, 32'b0);
        wait_idle(t0, k);
        check("R3 busy window", 32'(k), 32'(2 * n * (d + 1)));
        rd(A_DIN, v);
        check("R6 received word", v, pat >> (32 - n));
        check("R5 transmitted word", srx & mask(n), dout & mask(n));
        check("R7 select after shift", {29'b0, spi_cs_n}, fin ? 32'd7 : {29'b0, ~cs1h});
        rd(A_SHIFT, v);
        check("R4 command readback", v, {1'b0, cs1h, 1'b0, fin, 20'b0, 6'(nf)});
        check("R9 sclk idle low", {31'b0, spi_sclk}, 32'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", nerr, nchk + 1);
        $finish;
    end

    initial begin
        logic [31:0] v;
        longint t0, k;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1 cs_n", {29'b0, spi_cs_n}, 32'd7);
        check("R1 sclk/mosi", {30'b0, spi_sclk, spi_mosi}, 32'd0);
        rd(A_FUNC, v);  check("R1 func", v, 32'd0);
        rd(A_PINS, v);  check("R1 pin levels", v, 32'h0007_0000);
        rd(A_SHIFT, v); check("R1 command", v, 32'd0);
        rd(A_DIN, v);   check("R1 incoming", v, 32'd0);

        // R2 disabled engine ignores start
        wr(A_DOUT, 32'hFFFF_FFFF);
        wr(A_SHIFT, 32'h9400_0008);
        repeat (4) @(negedge clk);
        rd(A_SHIFT, v);
        check("R2 busy stays clear", {31'b0, v[31]}, 32'd0);
        check("R2 selects idle", {29'b0, spi_cs_n}, 32'd7);
        check("R2 sclk idle", {31'b0, spi_sclk}, 32'd0);

        wr(A_FUNC, 32'd1);

        // sweep: divider x length x select (R3 R4 R5 R6 R7 R9)
        foreach (v[i]) ;
        for (int di = 0; di < 4; di++) begin
            for (int ni = 1; ni <= 4; ni++) begin
                for (int c = 0; c < 3; c++) begin
                    int dd;
                    dd = (di == 3) ? 5 : di;
                    do_shift(dd, ni * 8, 3'(1 << c), 1'b1,
                             32'hA5C3_1E97 ^ 32'(di * 977 + ni * 31 + c),
                             32'h6B1D_F04C ^ 32'(c * 4099 + ni * 257));
                end
            end
        end
        // slowest divider
        do_shift(63, 8, 3'b010, 1'b1, 32'h0000_005A, 32'hC300_0000);
        // R4 count 0 and count above 32 both shift 32 bits
        do_shift(0, 0, 3'b001, 1'b1, 32'h1234_5678, 32'h8765_4321);
        do_shift(1, 40, 3'b100, 1'b1, 32'hDEAD_BEEF, 32'h0F0F_3C3C);

        // R7 held select across two shifts
        do_shift(0, 8, 3'b010, 1'b0, 32'h0000_00C1, 32'h7700_0000);
        check("R7 held select between shifts", {29'b0, spi_cs_n}, 32'd5);
        do_shift(0, 16, 3'b010, 1'b1, 32'h0000_B00B, 32'h1E2D_0000);

        // R8 write while busy is ignored
        wr(A_CLK, 32'd0);
        wr(A_DOUT, 32'hC0FF_EE11);
        stx = 32'h5AA5_3CC3; srx = '0;
        wr(A_SHIFT, {1'b1, 3'b001, 1'b0, 1'b1, 20'b0, 6'd32});
        t0 = cyc;
        repeat (4) @(negedge clk);
        wr(A_DOUT, 32'h0000_0000);
        wr(A_SHIFT, {1'b1, 3'b100, 1'b0, 1'b0, 20'b0, 6'd8});
        check("R8 original select still active", {29'b0, spi_cs_n}, 32'd6);
        wait_idle(t0, k);
        check("R8 length kept", 32'(k), 32'd64);
        rd(A_DIN, v);
        check("R8 received word kept", v, 32'h5AA5_3CC3);
        check("R8 transmitted word kept", srx, 32'hC0FF_EE11);
        rd(A_SHIFT, v);
        check("R8 command unchanged", v, {1'b0, 3'b001, 1'b0, 1'b1, 20'b0, 6'd32});

        // R10 pin-level register drives idle pins
        wr(A_PINS, 32'h0005_0003);
        check("R10 cs levels", {29'b0, spi_cs_n}, 32'd5);
        check("R10 sclk/mosi levels", {30'b0, spi_sclk, spi_mosi}, 32'd3);
        wr(A_PINS, 32'h0007_0000);
        check("R10 idle restored", {27'b0, spi_cs_n, spi_sclk, spi_mosi}, 32'h1C);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule